// File: doc/BRIEF.md
# Saturating Arithmetic Shift Left

This block shifts a signed two's-complement word left by a count and clamps the result when the shifted value no longer fits the word. When the value stays in range, the output is the plain left shift. When it overflows, the output becomes the largest positive or the most negative word, and the choice follows the sign of the source. The block is purely combinational, so it can sit in one execute stage of a datapath.

Overflow is found without a double-width product. An all-ones word is shifted right by the count to build a mask. The mask marks the top count+1 bits of the source, and those bits must be all zeros or all ones for the shift to be exact. A saturation flag reports that clamping happened. The flag is qualified by an execute-enable input, so a cancelled operation never raises it. The clamped value is still driven on the output when the enable is low.

Top module: `sat_shl_top`

## Requirements
- R1: The count input is 6 bits wide and every value from 0 to 63 is honoured; no bits of it are ignored.
- R2: When the top count+1 bits of the source are all zero, the result is the source shifted left by the count and the flag is 0.
- R3: When the top count+1 bits of the source are all one, the result is the source shifted left by the count and the flag is 0.
- R4: On overflow with source bit 31 clear, the result is 0x7FFFFFFF.
- R5: On overflow with source bit 31 set, the result is 0x80000000.
- R6: The flag is 1 exactly when overflow occurs and the execute-enable is 1. With the enable low, the flag is 0 and the result is still the clamped value.
- R7: For counts of 32 or more, a source of 0 gives 0 with flag 0, a source of 0xFFFFFFFF gives 0 with flag 0, and any other source saturates as in R4/R5.
- R8: A count of 0 returns the source unchanged and never raises the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 32 | Signed source word |
| shamt_i | input | 6 | Left shift count |
| exec_i | input | 1 | Execute enable that qualifies the saturation flag |
| result_o | output | 32 | Shifted or clamped result |
| sat_o | output | 1 | Saturation flag, set on overflow while executing |

## Verification
Two functions can meet in one evaluation: clamping to a limit and gating of the saturation flag by the execute enable. The bench drives overflowing operands with the enable both high and low. It expects the clamped value in both cases and a raised flag only in the first. A 64-bit signed reference shift compared against the 32-bit range judges every random and directed vector. Counts of 32 and above follow the mask rule given in R7.

// File: rtl/sat_shl_pkg.sv
package sat_shl_pkg;
   localparam int unsigned DEF_DATA_W = 32;
   localparam int unsigned DEF_CNT_W  = 6;

   typedef enum logic [0:0] {
      MASK_BY_SHIFT   = 1'b0,
      MASK_BY_COMPARE = 1'b1
   } mask_impl_e;
endpackage

// File: rtl/sat_shl_mask.sv
module sat_shl_mask
   import sat_shl_pkg::*;
#(
   parameter int unsigned DATA_W    = DEF_DATA_W,
   parameter int unsigned CNT_W     = DEF_CNT_W,
   parameter mask_impl_e  MASK_IMPL = MASK_BY_COMPARE
) (
   input  logic [CNT_W-1:0]  cnt_i,
   output logic [DATA_W-1:0] keep_o
);
   // keep_o = all-ones logically shifted right by cnt_i
   localparam logic [DATA_W-1:0] ONES = '1;

   generate
      if (MASK_IMPL == MASK_BY_SHIFT) begin : g_shift
         assign keep_o = ONES >> cnt_i;
      end else begin : g_cmp
         for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            // bit b survives while b + cnt < DATA_W
            assign keep_o[b] = ({1'b0, cnt_i} < (CNT_W+1)'(DATA_W - b))
                               && ((DATA_W - b) < (1 << (CNT_W+1)));
         end
      end
   endgenerate
endmodule

// File: rtl/sat_shl_detect.sv
module sat_shl_detect #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] keep_i,
   output logic              ovf_o
);
   logic [DATA_W-1:0] top_sel;   // marks the upper count+1 bits
   logic              top_zero;
   logic              top_ones;

   assign top_sel  = {1'b1, ~keep_i[DATA_W-1:1]};
   assign top_zero = ((src_i & top_sel) == '0);
   assign top_ones = ((src_i | ~top_sel) == '1);
   assign ovf_o    = !(top_zero || top_ones);
endmodule

// File: rtl/sat_shl_clamp.sv
module sat_shl_clamp #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 6
) (
   input  logic [DATA_W-1:0] src_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              ovf_i,
   input  logic              exec_i,
   output logic [DATA_W-1:0] res_o,
   output logic              sat_o
);
   localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

   logic [DATA_W-1:0] shifted;

   assign shifted = src_i << cnt_i;

   always_comb begin
      if (ovf_i) begin
         res_o = src_i[DATA_W-1] ? NEG_LIM : POS_LIM;
         sat_o = exec_i;
      end else begin
         res_o = shifted;
         sat_o = 1'b0;
      end
   end
endmodule

// File: rtl/sat_shl_top.sv
module sat_shl_top
   import sat_shl_pkg::*;
#(
   parameter int unsigned DATA_W    = DEF_DATA_W,
   parameter int unsigned CNT_W     = DEF_CNT_W,
   parameter mask_impl_e  MASK_IMPL = MASK_BY_COMPARE
) (
   input  logic [31:0] src_i,
   input  logic [5:0]  shamt_i,
   input  logic        exec_i,
   output logic [31:0] result_o,
   output logic        sat_o
);
   localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

   generate
      if (DATA_W != 32 || CNT_W != 6) begin : g_bad_cfg
         $error("sat_shl_top: port widths fixed at 32/6");
      end
      if ((1 << CNT_W) < DATA_W) begin : g_bad_cnt
         $error("sat_shl_top: count too narrow for data width");
      end
   endgenerate

   logic [DATA_W-1:0] keep;
   logic              ovf;

   sat_shl_mask #(
      .DATA_W   (DATA_W),
      .CNT_W    (CNT_W),
      .MASK_IMPL(MASK_IMPL)
   ) u_mask (
      .cnt_i (shamt_i),
      .keep_o(keep)
   );

   sat_shl_detect #(.DATA_W(DATA_W)) u_det (
      .src_i (src_i),
      .keep_i(keep),
      .ovf_o (ovf)
   );

   sat_shl_clamp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_clamp (
      .src_i (src_i),
      .cnt_i (shamt_i),
      .ovf_i (ovf),
      .exec_i(exec_i),
      .res_o (result_o),
      .sat_o (sat_o)
   );

   always_comb begin
      // R6
      flag_gate_chk: assert (!sat_o || exec_i);
      // R6
      flag_raise_chk: assert (!(ovf && exec_i) || sat_o);
      // R2
      no_overflow_chk: assert (ovf || !sat_o);
      // R4
      pos_clamp_chk: assert (!(ovf && !src_i[DATA_W-1]) || result_o == POS_LIM);
      // R5
      neg_clamp_chk: assert (!(ovf && src_i[DATA_W-1]) || result_o == NEG_LIM);
      // R8
      zero_cnt_chk: assert (shamt_i != '0 || (result_o == src_i && !sat_o));
      // R7
      zero_src_chk: assert (src_i != '0 || (result_o == '0 && !ovf));
   end
endmodule

// File: tb/sim_sat_shl_top.sv
module sim_sat_shl_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] src;
   logic [5:0]  cnt;
   logic        ex;
   logic [31:0] res;
   logic        sat;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   sat_shl_top u0 (
      .src_i   (src),
      .shamt_i (cnt),
      .exec_i  (ex),
      .result_o(res),
      .sat_o   (sat)
   );

   function automatic void model(input logic [31:0] s, input logic [5:0] c, input logic e,
                                 output logic [31:0] r, output logic f);
      longint w;
      bit     fits;
      if (c < 6'd32) begin
         w    = longint'($signed(s)) <<< c;
         fits = (w >= -64'sd2147483648) && (w <= 64'sd2147483647);
         r    = fits ? w[31:0] : (s[31] ? 32'h8000_0000 : 32'h7FFF_FFFF);
      end else begin
         fits = (s == 32'h0) || (s == 32'hFFFF_FFFF);
         r    = fits ? 32'h0 : (s[31] ? 32'h8000_0000 : 32'h7FFF_FFFF);
      end
      f = !fits && e;
   endfunction

   function automatic string tag_of(input logic [31:0] s, input logic [5:0] c, input logic [31:0] r,
                                    input logic f);
      if (c == 0) return "R8";
      if (c >= 32) return "R7";
      if (r == 32'h7FFF_FFFF && f) return "R4";
      if (r == 32'h8000_0000 && f) return "R5";
      if (s[31]) return "R3";
      return "R2";
   endfunction

   task automatic apply(input logic [31:0] s, input logic [5:0] c, input logic e, input string why);
      logic [31:0] er;
      logic        ef;
      @(posedge clk);
      src = s; cnt = c; ex = e;
      @(negedge clk);
      model(s, c, e, er, ef);
      checks++;
      if (res !== er || sat !== ef) begin
         errors++;
         $display("FAIL %s/%s src=%h cnt=%0d ex=%b got res=%h sat=%b exp res=%h sat=%b",
                  why, tag_of(s, c, er, ef), s, c, e, res, sat, er, ef);
      end
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] s;
      int          w;
      void'($urandom(32'h5A17_C0DE));
      src = '0; cnt = '0; ex = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      checks++;
      if (res !== 32'h0 || sat !== 1'b0) begin
         errors++;
         $display("FAIL R8 reset idle res=%h sat=%b exp 0/0", res, sat);
      end
      // directed corners
      apply(32'h1234_5678, 6'd0,  1'b1, "R8");
      apply(32'h8000_0000, 6'd0,  1'b1, "R8");
      apply(32'h0000_0001, 6'd30, 1'b1, "R2");
      apply(32'h0000_0001, 6'd31, 1'b1, "R4");
      apply(32'hFFFF_FFFF, 6'd31, 1'b1, "R3");
      apply(32'hC000_0000, 6'd1,  1'b1, "R3");
      apply(32'hA000_0000, 6'd1,  1'b1, "R5");
      apply(32'h4000_0000, 6'd1,  1'b1, "R4");
      apply(32'h4000_0000, 6'd1,  1'b0, "R6");
      apply(32'hA000_0000, 6'd1,  1'b0, "R6");
      apply(32'h0000_0000, 6'd63, 1'b1, "R7");
      apply(32'hFFFF_FFFF, 6'd32, 1'b1, "R7");
      apply(32'hFFFF_FFFF, 6'd63, 1'b1, "R7");
      apply(32'h0000_0001, 6'd32, 1'b1, "R7");
      apply(32'hFFFF_FFFE, 6'd40, 1'b1, "R7");
      apply(32'h0000_0003, 6'd33, 1'b0, "R1");
      apply(32'h0000_0001, 6'd16, 1'b1, "R1");
      // random: source sign-extended from a random width to hit both sides
      for (int i = 0; i < 3000; i++) begin
         w = $urandom_range(1, 32);
         s = $urandom;
         if (w < 32) s = 32'($signed(s << (32 - w)) >>> (32 - w));
         apply(s, 6'($urandom_range(0, 63)), 1'($urandom), "R1");
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule